// File: doc/BRIEF.md
# LRU-Position Dead-Line Predictor

This block estimates which lines of a set-associative last-level cache will not be touched again before they are evicted. A line that is dirty and predicted dead can then be written back early and slowly, while the memory bank is otherwise idle. The prediction is based only on where in the recency stack hits land. The cache reports every access with a hit flag and, on a hit, the recency position of the line it hit. Position 0 is the most recently used end and position WAYS-1 is the least recently used end.

Time is cut into slices of a fixed number of cycles. During a slice the block counts hits for each recency position and counts all accesses, hits and misses alike. At the end of the slice it copies these counts and scans them from the LRU end towards the MRU end. It keeps extending a run of positions while the run's summed hits, scaled by 2^FRAC_LOG2 (32 by default), stay strictly below the slice's access total. The length of that run becomes `dead_count` for the next slice. A query port turns a line's recency position and dirty flag into an eager-writeback verdict against the current `dead_count`.

Top module: `lru_dead_predictor`

## Requirements
- R1: An access with `acc_valid`=1 and `acc_hit`=1 counts one hit against recency position `acc_pos`. Position 0 is MRU and position WAYS-1 is LRU. Every valid access, hit or miss, counts once toward the slice's access total.
- R2: A slice lasts SLICE_CYCLES cycles from reset release. An access in a slice's last cycle belongs to that slice. Counting for the next slice starts from zero.
- R3: Within WAYS+1 cycles after a slice ends, `dead_count` takes the largest k such that the positions WAYS-1 down to WAYS-k together satisfy hits × 2^FRAC_LOG2 < accesses (strict). It then holds that value until the next slice ends.
- R4: `dead_count` is 0 from the cycle after a slice ends until the new value is published. It is also 0 before the first slice completes.
- R5: `eager_wb` is 1 exactly when `q_dirty`=1 and `q_pos` + `dead_count` ≥ WAYS. It is combinational from the query inputs.
- R6: A slice with no accesses yields `dead_count` = 0. A slice whose hit ties the limit exactly (hits × 32 = accesses) does not extend the run.
- R7: An active-low reset clears `dead_count` to 0 and discards all counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One cache access this cycle |
| acc_hit | input | 1 | The access hit |
| acc_pos | input | $clog2(WAYS) | Recency position of the hit line (0 = MRU) |
| q_pos | input | $clog2(WAYS) | Recency position of the queried line |
| q_dirty | input | 1 | The queried line is dirty |
| dead_count | output | $clog2(WAYS)+1 | Number of LRU-end positions predicted dead this slice |
| eager_wb | output | 1 | The queried line is an eager-writeback candidate |

## Verification
The assertions check, on every cycle:
- that a hit at a position adds exactly one to that position's live count;
- that the live access total restarts at zero after a boundary;
- that `dead_count` is zero while a scan runs and holds steady between publications;
- that `eager_wb` never rises for a clean line or while nothing is predicted dead.

Whether the published count is the right run length can only be shown by the bench's slices. These carry chosen hit histograms, including an exact tie at the 1/32 limit, a slice with no accesses and a slice of misses only. The same holds for slice alignment and the effect of a mid-slice reset.

// File: rtl/ldp_pkg.sv
`timescale 1ns/1ps
package ldp_pkg;
  // True when sum scaled by 2^shift stays strictly below total.
  function automatic logic below_quota(input logic [31:0] sum, input logic [31:0] total,
                                       input int shift);
    logic [63:0] scaled;
    scaled = {32'd0, sum} << shift;
    return scaled < {32'd0, total};
  endfunction

  // A line at recency position pos is dead when it lies in the last dead positions.
  function automatic logic line_dead(input int pos, input int dead, input int ways);
    return (pos + dead) >= ways;
  endfunction
endpackage

// File: rtl/ldp_slice_timer.sv
`timescale 1ns/1ps
module ldp_slice_timer #(
  parameter int SLICE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  output logic slice_end
);
  localparam int TW = $clog2(SLICE_CYCLES);

  logic [TW-1:0] cyc_q;

  assign slice_end = (cyc_q == TW'(SLICE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cyc_q <= '0;
    else if (slice_end) cyc_q <= '0;
    else                cyc_q <= cyc_q + 1'b1;
  end

  // R2
  slice_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_end |=> !slice_end);
endmodule

// File: rtl/ldp_hit_bank.sv
`timescale 1ns/1ps
module ldp_hit_bank #(
  parameter int WAYS = 16,
  parameter int CW   = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_hit,
  input  logic [$clog2(WAYS)-1:0]  acc_pos,
  input  logic                     slice_end,
  output logic [WAYS-1:0][CW-1:0]  snap_hits,
  output logic [CW-1:0]            snap_total
);
  localparam int PW = $clog2(WAYS);

  logic [WAYS-1:0][CW-1:0] live_hits, hits_nxt;
  logic [CW-1:0]           live_total, total_nxt;

  always_comb begin
    for (int i = 0; i < WAYS; i++)
      hits_nxt[i] = live_hits[i] + CW'(acc_valid && acc_hit && (acc_pos == PW'(i)));
    total_nxt = live_total + CW'(acc_valid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_hits  <= '0;
      live_total <= '0;
      snap_hits  <= '0;
      snap_total <= '0;
    end else if (slice_end) begin
      snap_hits  <= hits_nxt;
      snap_total <= total_nxt;
      live_hits  <= '0;
      live_total <= '0;
    end else begin
      live_hits  <= hits_nxt;
      live_total <= total_nxt;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_pos_chk
    // R1
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit && acc_pos == PW'(g) && !slice_end && $past(rst_n))
        |=> live_hits[g] == $past(live_hits[g]) + CW'(1));
  end

  // R2
  total_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_end |=> live_total == '0);
endmodule

// File: rtl/ldp_quota_scan.sv
`timescale 1ns/1ps
module ldp_quota_scan
  import ldp_pkg::*;
#(
  parameter int WAYS     = 16,
  parameter int CW       = 19,
  parameter int FRAC_LOG2 = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slice_end,
  input  logic [WAYS-1:0][CW-1:0]  snap_hits,
  input  logic [CW-1:0]            snap_total,
  output logic [$clog2(WAYS):0]    dead_count
);
  localparam int PW = $clog2(WAYS);

  logic          scanning;
  logic [PW-1:0] step;
  logic [PW-1:0] pos_now;
  logic [CW-1:0] sum_q, cand;
  logic [PW:0]   run_q;
  logic          fits, last_step, publish;

  assign pos_now   = PW'(WAYS - 1) - step;
  assign cand      = sum_q + snap_hits[pos_now];
  assign fits      = below_quota(32'(cand), 32'(snap_total), FRAC_LOG2);
  assign last_step = (step == PW'(WAYS - 1));
  assign publish   = scanning && (!fits || last_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanning   <= 1'b0;
      step       <= '0;
      sum_q      <= '0;
      run_q      <= '0;
      dead_count <= '0;
    end else if (slice_end) begin
      scanning   <= 1'b1;
      step       <= '0;
      sum_q      <= '0;
      run_q      <= '0;
      dead_count <= '0;
    end else if (scanning) begin
      step <= step + 1'b1;
      if (fits) begin
        sum_q <= cand;
        run_q <= run_q + 1'b1;
      end
      if (publish) begin
        scanning   <= 1'b0;
        dead_count <= fits ? run_q + 1'b1 : run_q;
      end
    end
  end

  // R4
  quiet_while_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> dead_count == '0);

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scanning && !slice_end && $past(rst_n)) |=> $stable(dead_count));

  // R3
  bounded_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_count <= (PW+1)'(WAYS));
endmodule

// File: rtl/lru_dead_predictor.sv
`timescale 1ns/1ps
module lru_dead_predictor
  import ldp_pkg::*;
#(
  parameter int WAYS         = 16,
  parameter int SLICE_CYCLES = 500000,
  parameter int FRAC_LOG2    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_hit,
  input  logic [$clog2(WAYS)-1:0] acc_pos,
  input  logic [$clog2(WAYS)-1:0] q_pos,
  input  logic                    q_dirty,
  output logic [$clog2(WAYS):0]   dead_count,
  output logic                    eager_wb
);
  localparam int CW = $clog2(SLICE_CYCLES + 1);

  logic                    slice_end;
  logic [WAYS-1:0][CW-1:0] snap_hits;
  logic [CW-1:0]           snap_total;

  ldp_slice_timer #(.SLICE_CYCLES(SLICE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .slice_end(slice_end));

  ldp_hit_bank #(.WAYS(WAYS), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_pos(acc_pos), .slice_end(slice_end),
    .snap_hits(snap_hits), .snap_total(snap_total));

  ldp_quota_scan #(.WAYS(WAYS), .CW(CW), .FRAC_LOG2(FRAC_LOG2)) u_scan (
    .clk(clk), .rst_n(rst_n), .slice_end(slice_end),
    .snap_hits(snap_hits), .snap_total(snap_total), .dead_count(dead_count));

  assign eager_wb = q_dirty && line_dead(int'(q_pos), int'(dead_count), WAYS);

  // R5
  clean_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eager_wb |-> q_dirty);

  // R5
  none_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_count == '0) |-> !eager_wb);
endmodule

// File: tb/tb_lru_dead_predictor.sv
`timescale 1ns/1ps
module tb_lru_dead_predictor;
  localparam int WAYS  = 16;
  localparam int SLICE = 256;
  localparam int PW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, acc_valid, acc_hit, q_dirty;
  logic [PW-1:0] acc_pos, q_pos;
  logic [PW:0]   dead_count;
  logic          eager_wb;

  lru_dead_predictor #(.WAYS(WAYS), .SLICE_CYCLES(SLICE), .FRAC_LOG2(5)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_pos(acc_pos), .q_pos(q_pos), .q_dirty(q_dirty),
    .dead_count(dead_count), .eager_wb(eager_wb));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {hits@15, hits@14, hits@13, hits@12, misses, expected dead_count}
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{1, 0, 5,  40, 40, 2},   // run stops at position 13
    '{0, 0, 0,  50, 10, 3},   // zero-hit positions extend run
    '{4, 0, 0,  30, 30, 0},   // LRU position already too busy
    '{2, 0, 0,  40, 22, 0},   // exact tie 64 vs 64 (R6)
    '{2, 1, 0,  40, 24, 1},   // 64 < 67, then 96 >= 67
    '{1, 1, 1,  60, 40, 3},   // 96 < 103
    '{0, 0, 0,   0,  0, 0},   // no accesses (R6)
    '{0, 0, 0,   0, 20, 16}   // misses only: all positions dead
  };

  task automatic drive_access(input int k, input int a, input int b, input int c,
                              input int d, input int x);
    acc_valid = 1'b1; acc_hit = 1'b1; acc_pos = '0;
    if      (k < a)             acc_pos = PW'(15);
    else if (k < a+b)           acc_pos = PW'(14);
    else if (k < a+b+c)         acc_pos = PW'(13);
    else if (k < a+b+c+d)       acc_pos = PW'(12);
    else if (k < a+b+c+d+x)     begin acc_hit = 1'b0; acc_pos = PW'(k % WAYS); end
    else                        begin acc_valid = 1'b0; acc_hit = 1'b1; end
  endtask

  task automatic query_checks(input int exp);
    if (exp > 0) begin
      q_pos = PW'(WAYS - exp); q_dirty = 1'b1; #0.4;
      check("R5 dirty line inside dead run", int'(eager_wb), 1);
    end
    if (exp < WAYS) begin
      q_pos = PW'(WAYS - exp - 1); q_dirty = 1'b1; #0.4;
      check("R5 dirty line just outside dead run", int'(eager_wb), 0);
    end
    q_pos = PW'(WAYS - 1); q_dirty = 1'b0; #0.4;
    check("R5 clean LRU line", int'(eager_wb), 0);
  endtask

  // One full slice; called at a negedge, returns at a negedge.
  task automatic run_slice(input int v, input int exp_prev, input bit has_prev,
                           input bit mid_reset);
    for (int cyc = 1; cyc <= SLICE; cyc++) begin
      if (cyc == 1)
        check("R4 zero right after boundary", int'(dead_count), 0);
      if (has_prev && cyc == 150)
        check("R1 R2 R3 R6 published run length", int'(dead_count), exp_prev);
      if (has_prev && cyc == 160) query_checks(exp_prev);
      if (v >= 0)
        drive_access(cyc - 1, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      else
        acc_valid = 1'b0;
      if (mid_reset && cyc == 170) rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      if (mid_reset && cyc == 171) begin
        check("R7 reset clears published count", int'(dead_count), 0);
        rst_n = 1'b1;
        return;
      end
    end
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; acc_valid = 1'b0; acc_hit = 1'b0; acc_pos = '0;
    q_pos = PW'(WAYS - 1); q_dirty = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset dead_count", int'(dead_count), 0);
    check("R4 nothing dead before first slice", int'(eager_wb), 0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++)
      run_slice(v, (v > 0) ? VEC[v-1][5] : 0, v > 0, 1'b0);
    // Last vector's result, then a mid-slice reset.
    run_slice(-1, VEC[NV-1][5], 1'b1, 1'b1);
    // After reset nothing is dead even for a dirty MRU line.
    q_pos = '0; q_dirty = 1'b1; #0.4;
    check("R7 R4 no candidate after reset", int'(eager_wb), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule